// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block gathers eight interrupt event lines into an 8-bit pending-flag register. Software can read and write that register through a small I/O register port. A second 8-bit register, the enable mask, gates the flags. Among the flagged and enabled sources, the lowest-numbered one wins. Its number is turned into the ROM address of its vector word, and the CPU fetches that word to load its program counter.

Toward the CPU the block offers a request line, an acknowledge input, a global interrupt-enable input and a vector address bus. Once a source has been granted, its vector address is frozen until the CPU acknowledges it. The acknowledge clears that source's flag. While no request is being presented (and throughout reset) the vector bus shows the initialization-vector address, 0x7FFF.

Pending flags deliberately have no reset. A reset pulse leaves them as they were, while the enable mask returns to zero, so nothing is requested until software enables sources again.

Top module: `vec_int_ctrl`

## Requirements
- R1: The pending-flag register is at I/O address 0x39. A write there with `ioWe` high loads all eight bits from `ioWrData`, and `ioRdData` returns the register whenever `ioAddr` is 0x39.
- R2: A 0-to-1 change of `evtIn[n]` between two clock edges sets flag bit n at the second edge. A line held high sets the bit only once, so a held level does not set it again after it has been cleared.
- R3: When a rising event on bit n coincides with a software write of 0 to bit n, or with an acknowledge that clears bit n, the bit ends up set.
- R4: Reset (`rstN` low) leaves the pending flags unchanged and clears the enable mask to 0. The mask is at I/O address 0x38 and is read and written like the flags. Any other address reads as 0.
- R5: A source is requested only if its flag bit and its mask bit are both 1. `irqReq` rises at the clock edge after the edge at which such a source first became pending and enabled.
- R6: Source 0 has the highest priority and source 7 the lowest. The granted source is the lowest-numbered flagged and enabled one at the grant edge.
- R7: While a grant is held, `vecAddr` equals 0x7FF0 + n for granted source n. It stays unchanged until the acknowledge, even if a higher-priority source becomes pending.
- R8: While no grant is held, including during reset, `vecAddr` equals 0x7FFF.
- R9: `irqAck` high while `irqReq` is high clears the granted source's flag at that edge and releases the grant. The next grant can be taken one edge later.
- R10: With `gie` low, `irqReq` is low, no new grant is taken, `irqAck` has no effect and no flag changes. A grant already held keeps its vector address.
- R11: `vecAddr` never takes any value in 0x7FF8 to 0x7FFE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| ioAddr | input | 8 | I/O register address |
| ioWrData | input | 8 | I/O write data |
| ioWe | input | 1 | I/O write strobe |
| ioRdData | output | 8 | I/O read data (combinational on `ioAddr`) |
| evtIn | input | 8 | Interrupt event lines, one per source, rising-edge sensitive |
| gie | input | 1 | Global interrupt enable from the CPU |
| irqAck | input | 1 | CPU acknowledge of the presented request |
| irqReq | output | 1 | Interrupt request to the CPU |
| vecAddr | output | 16 | ROM address of the vector word to fetch |

## Verification
Flag and mask changes from events, writes or an acknowledge appear on `ioRdData` just after the edge that samples them. The resulting `irqReq` and `vecAddr` appear one edge later, because the grant is registered. A change of `gie` reaches `irqReq` within the same cycle. The bench drives every input 1 ns after a rising edge. It advances its own cycle model of flags, mask and grant at the next edge, and compares all three outputs 1 ns after that edge, before it drives anything new. This makes every comparison fall in the cycle its requirement names.

// File: rtl/vic_pkg.sv
package vic_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_REQ  = 1'b1
  } ctlState_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic grantLoad;   // capture the winning source index
    logic grantClear;  // clear the flag of the held grant
    logic vecShow;     // present the held grant's vector address
  } vicStrobe_t;

endpackage

// File: rtl/vic_datapath.sv
module vic_datapath
  import vic_pkg::*;
#(
  parameter int                 NUM_SRC   = 8,
  parameter int                 ADDR_W    = 16,
  parameter int                 IO_AW     = 8,
  parameter logic [ADDR_W-1:0]  VEC_BASE  = 16'h7FF0,
  parameter logic [ADDR_W-1:0]  RESET_VEC = 16'h7FFF,
  parameter logic [IO_AW-1:0]   FLAG_ADDR = 8'h39,
  parameter logic [IO_AW-1:0]   MASK_ADDR = 8'h38,
  localparam int                IDX_W     = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [IO_AW-1:0]   ioAddr,
  input  logic [NUM_SRC-1:0] ioWrData,
  input  logic               ioWe,
  output logic [NUM_SRC-1:0] ioRdData,
  input  logic [NUM_SRC-1:0] evtIn,
  input  vicStrobe_t         strb,
  output logic               pendAny,
  output logic [ADDR_W-1:0]  vecAddr
);

  logic [NUM_SRC-1:0] flagQ;
  logic [NUM_SRC-1:0] flagNext;
  logic [NUM_SRC-1:0] maskQ;
  logic [NUM_SRC-1:0] evtPrevQ;
  logic [NUM_SRC-1:0] evtSet;
  logic [NUM_SRC-1:0] clrMask;
  logic [NUM_SRC-1:0] gated;
  logic               flagWrEn;
  logic               maskWrEn;
  logic [IDX_W-1:0]   pendIdx;
  logic [IDX_W-1:0]   grantQ;

  assign flagWrEn = ioWe && (ioAddr == FLAG_ADDR);
  assign maskWrEn = ioWe && (ioAddr == MASK_ADDR);

  // rising-edge detection, suppressed while reset is held
  assign evtSet = evtIn & ~evtPrevQ & {NUM_SRC{rstN}};

  always_ff @(posedge clk) begin
    if (!rstN) evtPrevQ <= '0;
    else       evtPrevQ <= evtIn;
  end

  assign clrMask = strb.grantClear ? (NUM_SRC'(1) << grantQ) : '0;

  // per-bit flag update: event set beats any clear
  for (genvar b = 0; b < NUM_SRC; b++) begin : g_flag
    assign flagNext[b] = evtSet[b] | (~clrMask[b] & (flagWrEn ? ioWrData[b] : flagQ[b]));
  end

  // pending flags carry no reset on purpose
  always_ff @(posedge clk) begin
    flagQ <= flagNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN)         maskQ <= '0;
    else if (maskWrEn) maskQ <= ioWrData;
  end

  assign gated   = flagQ & maskQ;
  assign pendAny = |gated;

  // fixed priority: lowest index wins
  always_comb begin
    pendIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (gated[i]) pendIdx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               grantQ <= '0;
    else if (strb.grantLoad) grantQ <= pendIdx;
  end

  assign vecAddr = strb.vecShow ? (VEC_BASE + {{(ADDR_W-IDX_W){1'b0}}, grantQ}) : RESET_VEC;

  always_comb begin
    ioRdData = '0;
    if (ioAddr == FLAG_ADDR)      ioRdData = flagQ;
    else if (ioAddr == MASK_ADDR) ioRdData = maskQ;
  end

  // ---------------- assertions ----------------
  p_vec_legal_r11: assert property (@(posedge clk) disable iff (!rstN)
    (vecAddr == RESET_VEC) ||
    ((vecAddr >= VEC_BASE) && (vecAddr < VEC_BASE + ADDR_W'(NUM_SRC))));

  p_vec_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.vecShow && !strb.grantClear) |=> $stable(vecAddr));

  p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.grantClear && !evtSet[grantQ]) |=> !flagQ[$past(grantQ)]);

  p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rstN)
    (|evtSet) |=> ((flagQ & $past(evtSet)) == $past(evtSet)));

  p_prio_r6: assert property (@(posedge clk) disable iff (!rstN)
    pendAny |-> (gated[pendIdx] &&
                 ((gated & ((NUM_SRC'(1) << pendIdx) - NUM_SRC'(1))) == '0)));

endmodule

// File: rtl/vic_control.sv
module vic_control
  import vic_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pendAny,
  input  logic       gie,
  input  logic       irqAck,
  output vicStrobe_t strb,
  output logic       irqReq
);

  ctlState_t stateQ;
  ctlState_t stateNext;

  always_comb begin
    stateNext       = stateQ;
    strb.grantLoad  = 1'b0;
    strb.grantClear = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (gie && pendAny) begin
          strb.grantLoad = 1'b1;
          stateNext      = ST_REQ;
        end
      end
      ST_REQ: begin
        if (gie && irqAck) begin
          strb.grantClear = 1'b1;
          stateNext       = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign strb.vecShow = (stateQ == ST_REQ);
  assign irqReq       = (stateQ == ST_REQ) && gie;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateNext;
  end

  // ---------------- assertions ----------------
  p_req_needs_gie_r10: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> gie);

  p_grant_needs_pend_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.grantLoad |-> (pendAny && gie));

  p_req_after_grant_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.grantLoad |=> strb.vecShow);

  p_release_r9: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && irqAck) |=> !strb.vecShow);

endmodule

// File: rtl/vec_int_ctrl.sv
module vec_int_ctrl
  import vic_pkg::*;
#(
  parameter int                 NUM_SRC   = 8,
  parameter int                 ADDR_W    = 16,
  parameter int                 IO_AW     = 8,
  parameter logic [ADDR_W-1:0]  VEC_BASE  = 16'h7FF0,
  parameter logic [ADDR_W-1:0]  RESET_VEC = 16'h7FFF,
  parameter logic [IO_AW-1:0]   FLAG_ADDR = 8'h39,
  parameter logic [IO_AW-1:0]   MASK_ADDR = 8'h38
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [IO_AW-1:0]   ioAddr,
  input  logic [NUM_SRC-1:0] ioWrData,
  input  logic               ioWe,
  output logic [NUM_SRC-1:0] ioRdData,
  input  logic [NUM_SRC-1:0] evtIn,
  input  logic               gie,
  input  logic               irqAck,
  output logic               irqReq,
  output logic [ADDR_W-1:0]  vecAddr
);

  vicStrobe_t strb;
  logic       pendAny;

  vic_control ctl_i (
    .clk     (clk),
    .rstN    (rstN),
    .pendAny (pendAny),
    .gie     (gie),
    .irqAck  (irqAck),
    .strb    (strb),
    .irqReq  (irqReq)
  );

  vic_datapath #(
    .NUM_SRC   (NUM_SRC),
    .ADDR_W    (ADDR_W),
    .IO_AW     (IO_AW),
    .VEC_BASE  (VEC_BASE),
    .RESET_VEC (RESET_VEC),
    .FLAG_ADDR (FLAG_ADDR),
    .MASK_ADDR (MASK_ADDR)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .ioAddr   (ioAddr),
    .ioWrData (ioWrData),
    .ioWe     (ioWe),
    .ioRdData (ioRdData),
    .evtIn    (evtIn),
    .strb     (strb),
    .pendAny  (pendAny),
    .vecAddr  (vecAddr)
  );

endmodule

// File: tb/vec_int_ctrl_tb_top.sv
module vec_int_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  ioAddr = 8'h38;
  logic [7:0]  ioWrData = '0;
  logic        ioWe = 1'b0;
  logic [7:0]  ioRdData;
  logic [7:0]  evtIn = '0;
  logic        gie = 1'b1;
  logic        irqAck = 1'b0;
  logic        irqReq;
  logic [15:0] vecAddr;

  int nChecks = 0;
  int nFail   = 0;

  // reference model state
  logic [7:0] mFlags = '0;
  logic [7:0] mMask  = '0;
  logic [7:0] mPrev  = '0;
  logic       mReq   = 1'b0;
  logic [2:0] mGrant = '0;

  always #10 clk = ~clk;  // 50 MHz

  vec_int_ctrl dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .ioAddr   (ioAddr),
    .ioWrData (ioWrData),
    .ioWe     (ioWe),
    .ioRdData (ioRdData),
    .evtIn    (evtIn),
    .gie      (gie),
    .irqAck   (irqAck),
    .irqReq   (irqReq),
    .vecAddr  (vecAddr)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] lowIdx(input logic [7:0] v);
    logic [2:0] r;
    r = '0;
    for (int i = 7; i >= 0; i--) if (v[i]) r = 3'(i);
    return r;
  endfunction

  function automatic logic [7:0] modelRd(input logic [7:0] a);
    if (a == 8'h39) return mFlags;
    if (a == 8'h38) return mMask;
    return 8'h00;
  endfunction

  task automatic compareAll();
    logic [15:0] expVec;
    expVec = mReq ? (16'h7FF0 + {13'd0, mGrant}) : 16'h7FFF;
    chk("R5 irqReq", {15'd0, irqReq}, {15'd0, mReq && gie});
    chk("R7 vecAddr", vecAddr, expVec);
    chk("R1 ioRdData", {8'd0, ioRdData}, {8'd0, modelRd(ioAddr)});
    chk("R11 no reserved vector", {15'd0, (vecAddr >= 16'h7FF8) && (vecAddr <= 16'h7FFE)}, 16'd0);
  endtask

  // one clock: drive, advance the model at the edge, compare after it
  task automatic step(input logic [7:0] e, input logic w, input logic [7:0] a,
                      input logic [7:0] d, input logic k, input logic g);
    logic [7:0] setB, clr, gatedB, nFlags, nMask;
    logic       nReq;
    logic [2:0] nGrant;
    evtIn = e; ioWe = w; ioAddr = a; ioWrData = d; irqAck = k; gie = g;
    setB   = e & ~mPrev;
    clr    = '0;
    nReq   = mReq;
    nGrant = mGrant;
    gatedB = mFlags & mMask;
    if (!mReq) begin
      if (g && (gatedB != 0)) begin
        nReq   = 1'b1;
        nGrant = lowIdx(gatedB);
      end
    end else if (g && k) begin
      nReq = 1'b0;
      clr  = 8'd1 << mGrant;
    end
    nFlags = (((w && a == 8'h39) ? d : mFlags) & ~clr) | setB;
    nMask  = (w && a == 8'h38) ? d : mMask;
    @(posedge clk);
    #1;
    mFlags = nFlags; mMask = nMask; mPrev = e; mReq = nReq; mGrant = nGrant;
    compareAll();
  endtask

  task automatic doReset(input logic [7:0] a);
    rstN = 1'b0; evtIn = '0; ioWe = 1'b0; ioAddr = a; irqAck = 1'b0; gie = 1'b1;
    for (int i = 0; i < 2; i++) begin
      @(posedge clk);
      #1;
      chk("R8 vecAddr in reset", vecAddr, 16'h7FFF);
      chk("R8 irqReq in reset", {15'd0, irqReq}, 16'd0);
    end
    mMask = '0; mPrev = '0; mReq = 1'b0; mGrant = '0;
    rstN = 1'b1;
    chk("R4 read after reset", {8'd0, ioRdData}, {8'd0, modelRd(a)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL R5 watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));

    // reset state
    doReset(8'h38);
    chk("R4 mask zero after reset", {8'd0, ioRdData}, 16'd0);

    // R1 flag register write and readback
    step(8'h00, 1'b1, 8'h39, 8'h00, 1'b0, 1'b1);
    step(8'h00, 1'b1, 8'h39, 8'hA5, 1'b0, 1'b1);
    chk("R1 flags readback", {8'd0, ioRdData}, 16'h00A5);
    step(8'h00, 1'b0, 8'h39, 8'h00, 1'b0, 1'b1);
    chk("R5 no request with mask zero", {15'd0, irqReq}, 16'd0);
    step(8'h00, 1'b0, 8'h3A, 8'h00, 1'b0, 1'b1);
    chk("R4 unmapped address reads zero", {8'd0, ioRdData}, 16'd0);

    // R4 flags survive reset
    doReset(8'h39);
    chk("R4 flags kept through reset", {8'd0, ioRdData}, 16'h00A5);

    // R2 R5 R7 event to request timing
    step(8'h00, 1'b1, 8'h39, 8'h00, 1'b0, 1'b1);
    step(8'h00, 1'b1, 8'h38, 8'hFF, 1'b0, 1'b1);
    step(8'h20, 1'b0, 8'h39, 8'h00, 1'b0, 1'b1);
    chk("R2 event sets flag", {8'd0, ioRdData}, 16'h0020);
    chk("R5 request not yet", {15'd0, irqReq}, 16'd0);
    step(8'h20, 1'b0, 8'h39, 8'h00, 1'b0, 1'b1);
    chk("R5 request one edge later", {15'd0, irqReq}, 16'd1);
    chk("R7 vector of source 5", vecAddr, 16'h7FF5);
    step(8'h22, 1'b0, 8'h39, 8'h00, 1'b0, 1'b1);
    chk("R7 vector held despite higher source", vecAddr, 16'h7FF5);
    step(8'h22, 1'b0, 8'h39, 8'h00, 1'b1, 1'b1);
    chk("R9 ack clears granted flag", {8'd0, ioRdData}, 16'h0002);
    chk("R8 idle vector", vecAddr, 16'h7FFF);
    step(8'h22, 1'b0, 8'h39, 8'h00, 1'b0, 1'b1);
    chk("R6 next grant source 1", vecAddr, 16'h7FF1);
    chk("R2 held level does not re-set", {8'd0, ioRdData}, 16'h0002);
    step(8'h22, 1'b0, 8'h39, 8'h00, 1'b1, 1'b1);
    step(8'h00, 1'b0, 8'h39, 8'h00, 1'b0, 1'b1);

    // R10 global enable
    step(8'h00, 1'b1, 8'h39, 8'h08, 1'b0, 1'b0);
    step(8'h00, 1'b0, 8'h39, 8'h00, 1'b0, 1'b0);
    chk("R10 no request with gie low", {15'd0, irqReq}, 16'd0);
    step(8'h00, 1'b0, 8'h39, 8'h00, 1'b1, 1'b0);
    chk("R10 ack ignored, flags kept", {8'd0, ioRdData}, 16'h0008);
    step(8'h00, 1'b0, 8'h39, 8'h00, 1'b0, 1'b1);
    chk("R10 request once enabled", {15'd0, irqReq}, 16'd1);
    step(8'h00, 1'b0, 8'h39, 8'h00, 1'b0, 1'b0);
    chk("R10 request masked", {15'd0, irqReq}, 16'd0);
    chk("R10 vector kept while masked", vecAddr, 16'h7FF3);
    step(8'h00, 1'b0, 8'h39, 8'h00, 1'b1, 1'b1);

    // R3 event beats clears
    step(8'h10, 1'b1, 8'h39, 8'h00, 1'b0, 1'b1);
    chk("R3 event beats software clear", {8'd0, ioRdData}, 16'h0010);
    step(8'h10, 1'b0, 8'h39, 8'h00, 1'b0, 1'b1);
    step(8'h00, 1'b0, 8'h39, 8'h00, 1'b0, 1'b1);
    step(8'h10, 1'b0, 8'h39, 8'h00, 1'b1, 1'b1);
    chk("R3 event beats ack clear", {8'd0, ioRdData}, 16'h0010);
    step(8'h10, 1'b0, 8'h39, 8'h00, 1'b0, 1'b1);
    chk("R3 re-request source 4", vecAddr, 16'h7FF4);
    step(8'h10, 1'b0, 8'h39, 8'h00, 1'b1, 1'b1);

    // R6 priority order
    step(8'h00, 1'b1, 8'h39, 8'hC8, 1'b0, 1'b1);
    step(8'h00, 1'b0, 8'h39, 8'h00, 1'b0, 1'b1);
    chk("R6 source 3 first", vecAddr, 16'h7FF3);
    step(8'h00, 1'b0, 8'h39, 8'h00, 1'b1, 1'b1);
    step(8'h00, 1'b0, 8'h39, 8'h00, 1'b0, 1'b1);
    chk("R6 source 6 next", vecAddr, 16'h7FF6);
    step(8'h00, 1'b0, 8'h39, 8'h00, 1'b1, 1'b1);
    step(8'h00, 1'b0, 8'h39, 8'h00, 1'b0, 1'b1);
    chk("R6 source 7 last", vecAddr, 16'h7FF7);
    step(8'h00, 1'b0, 8'h39, 8'h00, 1'b1, 1'b1);

    // constrained random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] e, a, d;
      logic       w, k, g;
      int         sel;
      if (($urandom % 500) == 0) doReset(8'h39);
      e   = 8'($urandom) & 8'($urandom) & 8'($urandom);
      w   = (($urandom % 4) == 0);
      sel = int'($urandom % 4);
      a   = (sel == 0) ? 8'h38 : (sel == 3) ? 8'($urandom) : 8'h39;
      d   = 8'($urandom);
      k   = 1'($urandom % 2);
      g   = (($urandom % 5) != 0);
      step(e, w, a, d, k, g);
    end

    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule